// File: doc/BRIEF.md
# Store-and-Forward Packet Gate

The gate sits on a single-clock streaming path carrying 64-bit data words with a 4-bit user sideband and an end-of-packet flag. Every incoming packet is written into an internal buffer. The downstream side sees nothing of the packet until its final word has been accepted. At that point the whole packet becomes visible and can be drained back to back. A packet can be found faulty only while it is arriving, for example by a receive MAC that checks the frame at its end. Such a packet is thrown away inside the gate and never reaches the consumer.

The write side keeps two pointers. The speculative pointer advances with every stored word. The committed pointer moves only when a clean packet ends. The read side drains up to the committed pointer and no further. When a packet ends with its error flag set, the speculative pointer is rolled back to the committed one. A packet larger than the whole buffer cannot be committed, so it is swallowed and discarded, and the input never locks up. The buffer depth is 2^ADDR_W words. The default of 11 gives 16 KiB, which covers two frames of about 8 KB or one 9900-byte jumbo frame.

Top module: `pkt_hold_gate`

## Requirements
- R1: While a packet is only partly received, none of its words appears on the output; `out_valid` stays low if no earlier packet is committed.
- R2: One cycle after the last word of a clean packet is accepted, `out_valid` rises. The words leave in arrival order with data and user bits unchanged, and `out_last` is high on the final word only.
- R3: Bit 3 of `in_user` is the error flag. If it is set on any word of a packet, including the last word, the whole packet is discarded. Later packets are unaffected.
- R4: The buffer holds 2^ADDR_W words. A packet of exactly that length is kept. When committed data plus the packet in progress fill the buffer, `in_ready` goes low until the reader frees a word, and no word is lost.
- R5: A packet longer than 2^ADDR_W words is accepted in full with `in_ready` held high once it alone fills the buffer. It is then discarded, and the next packet passes normally.
- R6: A packet consisting of a single word with `in_last` set is stored and forwarded like any other.
- R7: `rst` or `clr` empties the gate. In the following cycle `out_valid` is low and `in_ready` is high. Both committed and partly received packets are lost.
- R8: While `out_valid` is high and `out_ready` is low, the output word and its flags hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous flush, active high |
| in_data | input | DATA_W | Input data word |
| in_user | input | USER_W | Input sideband; bit 3 flags an errored packet |
| in_last | input | 1 | Input end-of-packet marker |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Gate can take the input word |
| out_data | output | DATA_W | Output data word |
| out_user | output | USER_W | Output sideband |
| out_last | output | 1 | Output end-of-packet marker |
| out_valid | output | 1 | Committed word available |
| out_ready | input | 1 | Consumer takes the output word |

## Verification
Draining one packet and storing the next can fall in the same cycle. The full check that gates `in_ready` then depends on a read pointer that is moving while the speculative pointer also moves. The bench provokes this by filling the buffer with a committed packet plus part of a second one, so that `in_ready` drops. It then releases `out_ready` while the sender keeps pushing. The check is that the stall holds at the exact word count, and that every word of both packets comes out once and in order. A packet end that commits or rewinds while the reader is active is judged the same way, against the bench's own list of expected words.

// File: rtl/gate_pkg.sv
package gate_pkg;

  // Sideband bit that marks a packet as bad
  localparam int unsigned ERR_BIT_DFLT = 3;

  // Write-side mode: storing words, or swallowing an oversize packet
  typedef enum logic {
    WM_STORE   = 1'b0,
    WM_DISCARD = 1'b1
  } wr_mode_e;

endpackage

// File: rtl/gate_ram.sv
module gate_ram #(
  parameter int unsigned WIDTH  = 69,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read keeps the head word on the output with no latency
  assign rdata = mem[raddr];

endmodule

// File: rtl/gate_wr_side.sv
module gate_wr_side
  import gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic            in_err,
  output logic            in_ready,
  input  logic [ADDR_W:0] rd_ptr,
  output logic            wr_en,
  output logic [ADDR_W:0] spec_ptr,
  output logic [ADDR_W:0] commit_ptr,
  output logic            ev_commit,
  output logic            ev_rewind,
  output logic            ev_overflow
);

  localparam int unsigned PW = ADDR_W + 1;
  localparam logic [PW-1:0] CAP = {1'b1, {ADDR_W{1'b0}}};

  // Words between two pointers, modulo twice the depth
  function automatic logic [PW-1:0] ptr_gap(input logic [PW-1:0] ahead,
                                            input logic [PW-1:0] behind);
    return ahead - behind;
  endfunction

  wr_mode_e     mode_q;
  logic         bad_q;
  logic [PW-1:0] spec_q, commit_q;

  logic full, pkt_hogs, in_fire, bad_now, store_ok;

  assign full     = (ptr_gap(spec_q, rd_ptr) == CAP);
  assign pkt_hogs = (ptr_gap(spec_q, commit_q) == CAP);
  // When the open packet alone fills the buffer nothing can drain, so keep taking words
  assign in_ready = (mode_q == WM_DISCARD) || !full || pkt_hogs;
  assign in_fire  = in_valid && in_ready;
  assign bad_now  = bad_q || in_err;
  assign store_ok = (mode_q == WM_STORE) && !full;

  assign wr_en       = in_fire && store_ok;
  assign ev_commit   = in_fire && in_last && store_ok && !bad_now;
  assign ev_rewind   = in_fire && in_last && !(store_ok && !bad_now);
  assign ev_overflow = in_fire && (mode_q == WM_STORE) && full;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mode_q   <= WM_STORE;
      bad_q    <= 1'b0;
      spec_q   <= '0;
      commit_q <= '0;
    end else if (in_fire) begin
      if (in_last) begin
        mode_q <= WM_STORE;
        bad_q  <= 1'b0;
        if (ev_commit) begin
          spec_q   <= spec_q + 1'b1;
          commit_q <= spec_q + 1'b1;
        end else begin
          spec_q <= commit_q;
        end
      end else begin
        bad_q <= bad_now;
        if (store_ok) spec_q <= spec_q + 1'b1;
        if (ev_overflow) mode_q <= WM_DISCARD;
      end
    end
  end

  assign spec_ptr   = spec_q;
  assign commit_ptr = commit_q;

  // R4
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst || clr)
    ptr_gap(spec_q, rd_ptr) <= CAP);

  // R2
  commit_only_at_end_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (in_fire && !in_last) |=> $stable(commit_q));

  // R3
  rewind_to_commit_chk: assert property (@(posedge clk) disable iff (rst || clr)
    ev_rewind |=> (spec_q == $past(commit_q)));

  // R5
  overflow_swallow_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (ev_overflow && !in_last) |=> in_ready);

endmodule

// File: rtl/gate_rd_side.sv
module gate_rd_side #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [ADDR_W:0] commit_ptr,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [ADDR_W:0] rd_ptr,
  output logic            ev_read
);

  logic [ADDR_W:0] rd_q;

  assign out_valid = (rd_q != commit_ptr);
  assign ev_read   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst || clr)   rd_q <= '0;
    else if (ev_read) rd_q <= rd_q + 1'b1;
  end

  assign rd_ptr = rd_q;

  // R2
  read_step_chk: assert property (@(posedge clk) disable iff (rst || clr)
    ev_read |=> (rd_q == $past(rd_q) + 1'b1));

endmodule

// File: rtl/pkt_hold_gate.sv
module pkt_hold_gate
  import gate_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned USER_W  = 4,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned ERR_BIT = ERR_BIT_DFLT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [USER_W-1:0] in_user,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [USER_W-1:0] out_user,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);

  localparam int unsigned ENTRY_W = 1 + USER_W + DATA_W;
  localparam int unsigned PW      = ADDR_W + 1;

  function automatic logic [PW-1:0] ptr_gap(input logic [PW-1:0] ahead,
                                            input logic [PW-1:0] behind);
    return ahead - behind;
  endfunction

  logic [PW-1:0]      spec_ptr, commit_ptr, rd_ptr;
  logic               wr_en, ev_commit, ev_rewind, ev_overflow, ev_read;
  logic [ENTRY_W-1:0] wr_entry, rd_entry;

  gate_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_err     (in_user[ERR_BIT]),
    .in_ready   (in_ready),
    .rd_ptr     (rd_ptr),
    .wr_en      (wr_en),
    .spec_ptr   (spec_ptr),
    .commit_ptr (commit_ptr),
    .ev_commit  (ev_commit),
    .ev_rewind  (ev_rewind),
    .ev_overflow(ev_overflow)
  );

  gate_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .commit_ptr(commit_ptr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rd_ptr    (rd_ptr),
    .ev_read   (ev_read)
  );

  assign wr_entry = {in_last, in_user, in_data};

  gate_ram #(.WIDTH(ENTRY_W), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(spec_ptr[ADDR_W-1:0]),
    .wdata(wr_entry),
    .raddr(rd_ptr[ADDR_W-1:0]),
    .rdata(rd_entry)
  );

  assign {out_last, out_user, out_data} = rd_entry;

  // R1
  read_behind_commit_chk: assert property (@(posedge clk) disable iff (rst || clr)
    ptr_gap(commit_ptr, rd_ptr) <= ptr_gap(spec_ptr, rd_ptr));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_user) && $stable(out_last)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_valid && in_ready));

  // R3
  no_commit_on_rewind_chk: assert property (@(posedge clk) disable iff (rst || clr)
    ev_rewind |=> $stable(commit_ptr));

endmodule

// File: tb/test_pkt_hold_gate.sv
`timescale 1ns/1ps
module test_pkt_hold_gate;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [63:0] in_data = '0;
  logic [3:0]  in_user = '0;
  logic        in_last = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] out_data;
  logic [3:0]  out_user;
  logic        out_last;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int sent_words = 0;
  int pkt_id = 1;
  logic [68:0] exp_q[$];

  always #4 clk = ~clk;

  pkt_hold_gate #(.ADDR_W(AW)) i_pkt_hold_gate (
    .clk(clk), .rst(rst), .clr(clr),
    .in_data(in_data), .in_user(in_user), .in_last(in_last),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_user(out_user), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard: every output transfer must match the head of the expected list (R2)
  always @(negedge clk) begin
    #1;
    if (!rst && !clr && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected output word", {out_last, out_user, out_data}, 0);
      end else begin
        logic [68:0] e;
        e = exp_q.pop_front();
        check({out_last, out_user, out_data} == e, "R2", "output word", 
              {out_last, out_user, out_data}, e);
      end
    end
  end

  task automatic send_pkt(input int len, input int err_at, input bit hold_chk, input bit with_end);
    bit keep;
    keep = with_end && (err_at < 0) && (len <= DEPTH);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {32'(pkt_id), 32'(i)};
      in_user  = {(i == err_at), 3'(i)};
      in_last  = with_end && (i == len - 1);
      while (!in_ready) @(negedge clk);
      if (hold_chk) check(out_valid == 1'b0, "R1", "valid before end", out_valid, 0);
      if (keep) exp_q.push_back({in_last, in_user, in_data});
      @(posedge clk);
      sent_words++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_user  = '0;
    pkt_id++;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, "words left unread", exp_q.size(), 0);
    check(out_valid == 1'b0, req, "valid after drain", out_valid, 0);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R7", "valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "ready after reset", in_ready, 1);
  endtask

  task automatic t_hold_release;
    logic [63:0] d0;
    out_ready = 1'b0;
    send_pkt(3, -1, 1'b1, 1'b1);
    check(out_valid == 1'b1, "R2", "valid after last", out_valid, 1);
    check(out_last == 1'b0, "R2", "last on first word", out_last, 0);
    d0 = out_data;
    repeat (3) @(negedge clk);
    check(out_data == d0 && out_valid, "R8", "held head word", out_data, d0);
    drain("R2");
    // Gate open for reading the whole time: still nothing before the end
    out_ready = 1'b1;
    send_pkt(4, -1, 1'b1, 1'b1);
    drain("R1");
  endtask

  task automatic t_single;
    send_pkt(1, -1, 1'b1, 1'b1);
    check(out_valid && out_last, "R6", "single word valid+last", {out_valid, out_last}, 2'b11);
    drain("R6");
  endtask

  task automatic t_errors;
    out_ready = 1'b0;
    send_pkt(4, 3, 1'b0, 1'b1);
    send_pkt(5, 2, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R3", "errored packets visible", out_valid, 0);
    send_pkt(2, -1, 1'b0, 1'b1);
    drain("R3");
  endtask

  task automatic t_exact_fit;
    out_ready = 1'b0;
    send_pkt(DEPTH, -1, 1'b0, 1'b1);
    check(out_valid == 1'b1, "R4", "full-size packet kept", out_valid, 1);
    check(in_ready == 1'b0, "R4", "ready when full", in_ready, 0);
    drain("R4");
  endtask

  task automatic t_stall;
    int base;
    out_ready = 1'b0;
    send_pkt(10, -1, 1'b0, 1'b1);
    base = sent_words;
    fork
      send_pkt(10, -1, 1'b0, 1'b1);
    join_none
    repeat (20) @(negedge clk);
    check(sent_words - base == DEPTH - 10, "R4", "words taken before stall",
          sent_words - base, DEPTH - 10);
    check(in_ready == 1'b0, "R4", "ready during stall", in_ready, 0);
    out_ready = 1'b1;
    wait fork;
    drain("R4");
  endtask

  task automatic t_oversize;
    int base;
    out_ready = 1'b0;
    base = sent_words;
    send_pkt(DEPTH + 4, -1, 1'b0, 1'b1);
    check(sent_words - base == DEPTH + 4, "R5", "oversize words accepted",
          sent_words - base, DEPTH + 4);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R5", "oversize packet visible", out_valid, 0);
    check(in_ready == 1'b1, "R5", "ready after oversize", in_ready, 1);
    send_pkt(3, -1, 1'b0, 1'b1);
    drain("R5");
  endtask

  task automatic t_flush;
    out_ready = 1'b0;
    send_pkt(4, -1, 1'b0, 1'b1);
    send_pkt(2, -1, 1'b0, 1'b0);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_q.delete();
    check(out_valid == 1'b0, "R7", "valid after clear", out_valid, 0);
    check(in_ready == 1'b1, "R7", "ready after clear", in_ready, 1);
    send_pkt(2, -1, 1'b1, 1'b1);
    drain("R7");
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hold_release();
    t_single();
    t_errors();
    t_exact_fit();
    t_stall();
    t_oversize();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule